// File: doc/BRIEF.md
# Pipelined Partial-Product Tree Multiplier

This block multiplies an A_W-bit multiplicand by a B_W-bit multiplier. The product is A_W+B_W bits wide, so no result is ever truncated. The first registered stage builds one partial product for each multiplier bit. Each partial product is the multiplicand, shifted by that bit's index and masked by the bit, and it is carried at the full product width.

A tree of registered adders then sums adjacent pairs, one tree level per clock, until a single operand remains. A level with an odd operand count forwards its last operand through a register. The block accepts a new operand pair on every clock. Each request carries its own signed/unsigned flag, so requests of either kind can follow each other back to back. The result emerges after a fixed number of clocks that does not depend on the operand values.

Top module: `pptm_mul`

## Requirements
- R1: With `signed_mode` low, `product` equals the exact unsigned product of `a_in` and `b_in`, A_W+B_W bits wide, so all-ones by all-ones is exact.
- R2: With `signed_mode` high, both operands are two's complement and `product` is their exact two's-complement product, including the most-negative by most-negative case.
- R3: `out_valid` rises exactly LAT = clog2(B_W)+2 clocks after the clock edge that samples `in_valid` high, and the latency is the same for a zero, sparse or all-ones multiplier.
- R4: Requests on consecutive clocks yield results on consecutive clocks, in the order they were accepted.
- R5: `signed_mode` is captured along with the operands of its request, so alternating signed and unsigned requests each get their own interpretation.
- R6: Synchronous reset forces `out_valid` low on the next clock, and any request in flight at the time never emerges. After reset, `out_valid` stays low for at least LAT clocks.
- R7: Cycles with `in_valid` low never produce an `out_valid` pulse, whatever values are on the operand inputs.
- R8: The operand widths may differ (defaults 8 and 6). A multiplier width that gives an odd operand count at some tree level still yields exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for the operands on this clock |
| signed_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| a_in | input | A_W | Multiplicand |
| b_in | input | B_W | Multiplier |
| out_valid | output | 1 | The product on `product` is valid |
| product | output | A_W+B_W | Registered product |

## Verification
The bound checker runs a behavioural multiplier and a valid shift line of depth LAT alongside the block. On every cycle it compares each valid product and each `out_valid` level against them. It also checks that reset clears `out_valid` and that `out_valid` stays quiet while the pipeline refills. The bench scenarios cover what a per-cycle property cannot show well:
- a reset taken while requests are in flight, confirming that none of them appears later;
- that gaps filled with garbage inputs add no results;
- that ordering holds across long back-to-back runs of mixed signed and unsigned requests;
- the extreme operand corners.

// File: rtl/pptm_pkg.sv
package pptm_pkg;

  // operand count remaining after lvl pairwise tree levels
  function automatic int ops_at(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 1) / 2;
    return c;
  endfunction

endpackage

// File: rtl/pptm_in_stage.sv
module pptm_in_stage #(
  parameter int A_W = 8,
  parameter int B_W = 6
) (
  input  logic           clk,
  input  logic           signed_mode,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           mode_q,
  output logic [A_W-1:0] a_q,
  output logic [B_W-1:0] b_q
);
  // data registers carry no reset; only the valid line is cleared
  always_ff @(posedge clk) begin
    mode_q <= signed_mode;
    a_q    <= a_in;
    b_q    <= b_in;
  end
endmodule

// File: rtl/pptm_pp_gen.sv
module pptm_pp_gen #(
  parameter int A_W = 8,
  parameter int B_W = 6,
  localparam int P_W = A_W + B_W
) (
  input  logic                    clk,
  input  logic                    mode_i,
  input  logic [A_W-1:0]          a_i,
  input  logic [B_W-1:0]          b_i,
  output logic [B_W-1:0][P_W-1:0] pp_q
);
  logic [P_W-1:0] ext_a;

  // sign-extend the multiplicand in signed mode, zero-extend otherwise
  assign ext_a = {{B_W{mode_i & a_i[A_W-1]}}, a_i};

  for (genvar i = 0; i < B_W; i++) begin : g_row
    localparam bit IS_TOP = (i == B_W - 1);
    logic [P_W-1:0] shifted;
    assign shifted = b_i[i] ? (ext_a << i) : '0;
    if (IS_TOP) begin : g_top
      // top multiplier bit has negative weight in two's complement
      always_ff @(posedge clk)
        pp_q[i] <= mode_i ? (~shifted + 1'b1) : shifted;
    end else begin : g_plain
      always_ff @(posedge clk)
        pp_q[i] <= shifted;
    end
  end
endmodule

// File: rtl/pptm_tree_level.sv
module pptm_tree_level #(
  parameter int P_W = 14,
  parameter int CIN = 6,
  localparam int COUT = (CIN + 1) / 2
) (
  input  logic                     clk,
  input  logic [CIN-1:0][P_W-1:0]  ops_i,
  output logic [COUT-1:0][P_W-1:0] ops_o
);
  for (genvar j = 0; j < COUT; j++) begin : g_node
    if (2 * j + 1 < CIN) begin : g_add
      always_ff @(posedge clk)
        ops_o[j] <= ops_i[2*j] + ops_i[2*j+1];
    end else begin : g_pass
      // unpaired operand of an odd-sized level
      always_ff @(posedge clk)
        ops_o[j] <= ops_i[2*j];
    end
  end
endmodule

// File: rtl/pptm_valid_pipe.sv
module pptm_valid_pipe #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vld_i,
  output logic vld_o
);
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (DEPTH == 1) sh_q <= vld_i;
    else sh_q <= {sh_q[DEPTH-2:0], vld_i};
  end

  assign vld_o = sh_q[DEPTH-1];
endmodule

// File: rtl/pptm_mul.sv
module pptm_mul #(
  parameter int A_W = 8,
  parameter int B_W = 6,
  localparam int P_W    = A_W + B_W,
  localparam int LEVELS = $clog2(B_W),
  localparam int LAT    = LEVELS + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           signed_mode,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           out_valid,
  output logic [P_W-1:0] product
);
  logic                    mode_q;
  logic [A_W-1:0]          a_q;
  logic [B_W-1:0]          b_q;
  logic [B_W-1:0][P_W-1:0] pp_q;

  pptm_in_stage #(.A_W(A_W), .B_W(B_W)) in_i (
    .clk(clk), .signed_mode(signed_mode), .a_in(a_in), .b_in(b_in),
    .mode_q(mode_q), .a_q(a_q), .b_q(b_q)
  );

  pptm_pp_gen #(.A_W(A_W), .B_W(B_W)) pp_i (
    .clk(clk), .mode_i(mode_q), .a_i(a_q), .b_i(b_q), .pp_q(pp_q)
  );

  for (genvar l = 0; l <= LEVELS; l++) begin : lv
    localparam int CNT = pptm_pkg::ops_at(B_W, l);
    logic [CNT-1:0][P_W-1:0] ops;
    if (l == 0) begin : g_src
      assign ops = pp_q;
    end else begin : g_sum
      pptm_tree_level #(.P_W(P_W), .CIN(pptm_pkg::ops_at(B_W, l - 1))) lvl_i (
        .clk(clk), .ops_i(lv[l-1].ops), .ops_o(ops)
      );
    end
  end

  assign product = lv[LEVELS].ops[0];

  pptm_valid_pipe #(.DEPTH(LAT)) vp_i (
    .clk(clk), .rst(rst), .vld_i(in_valid), .vld_o(out_valid)
  );
endmodule

// File: rtl/pptm_chk.sv
module pptm_chk #(
  parameter int A_W = 8,
  parameter int B_W = 6,
  localparam int P_W = A_W + B_W,
  localparam int LAT = $clog2(B_W) + 2
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           signed_mode,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic           out_valid,
  input logic [P_W-1:0] product
);
  logic signed [P_W-1:0] sa, sb;
  logic [P_W-1:0] model;
  logic [P_W-1:0] exp_sh [LAT];
  logic [LAT-1:0] vld_sh;
  int unsigned    since_rst;

  assign sa    = {{B_W{a_in[A_W-1]}}, a_in};
  assign sb    = {{A_W{b_in[B_W-1]}}, b_in};
  assign model = signed_mode ? P_W'(sa * sb)
                             : P_W'({{B_W{1'b0}}, a_in} * {{A_W{1'b0}}, b_in});

  always_ff @(posedge clk) begin
    exp_sh[0] <= model;
    for (int k = 1; k < LAT; k++) exp_sh[k] <= exp_sh[k-1];
    if (rst) begin
      vld_sh    <= '0;
      since_rst <= 0;
    end else begin
      vld_sh <= {vld_sh[LAT-2:0], in_valid};
      if (since_rst < LAT) since_rst <= since_rst + 1;
    end
  end

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vld_sh[LAT-1]);

  // R1 R2
  product_model_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> product == exp_sh[LAT-1]);

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R6
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < LAT) |-> !out_valid);
endmodule

bind pptm_mul pptm_chk #(.A_W(A_W), .B_W(B_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
  .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .product(product)
);

// File: tb/pptm_mul_tb_top.sv
`timescale 1ns/1ps
module pptm_mul_tb_top;
  localparam int A_W = 8;
  localparam int B_W = 6;
  localparam int P_W = A_W + B_W;
  localparam int LAT = $clog2(B_W) + 2;

  typedef struct {
    logic [P_W-1:0] p;
    int             cyc;
    string          req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed_mode = 1'b0;
  logic [A_W-1:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic out_valid;
  logic [P_W-1:0] product;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pptm_mul #(.A_W(A_W), .B_W(B_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
    .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [P_W-1:0] ref_mul(input logic [A_W-1:0] a,
                                             input logic [B_W-1:0] b, input bit s);
    longint x, y;
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    return P_W'(x * y);
  endfunction

  // driver: one request per call, inputs change at negedge
  task automatic drive(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                       input bit s, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; signed_mode = s; a_in = a; b_in = b;
    it.p = ref_mul(a, b, s); it.cyc = cyc; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input bit garbage);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (garbage) begin
        a_in = A_W'($urandom); b_in = B_W'($urandom); signed_mode = $urandom;
      end
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(0, "R7 unexpected out_valid", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(product == it.p, it.req, product, it.p);
        check(cyc == it.cyc + LAT, "R3 latency", cyc - it.cyc, LAT);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    // R6 reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 quiet after reset", out_valid, 0);
    end

    // R1 unsigned corners, R3 zero/sparse/dense multipliers
    drive(8'd0,   6'd37, 0, "R1 zero multiplicand");
    drive(8'd173, 6'd0,  0, "R3 zero multiplier");
    drive(8'd255, 6'd63, 0, "R1 all-ones");
    drive(8'd1,   6'd1,  0, "R1 one by one");
    drive(8'd91,  6'd32, 0, "R3 sparse multiplier");
    drive(8'd200, 6'd63, 0, "R3 dense multiplier");
    idle(LAT + 2, 0);

    // R2 signed corners
    drive(8'h80, 6'h20, 1, "R2 min by min");
    drive(8'h80, 6'h1f, 1, "R2 min by max");
    drive(8'h7f, 6'h3f, 1, "R2 max by -1");
    drive(8'hff, 6'h3f, 1, "R2 -1 by -1");
    drive(8'h05, 6'h3d, 1, "R2 positive by negative");
    idle(LAT + 2, 0);

    // R4 R5 R8 back-to-back mixed modes
    for (int i = 0; i < 200; i++)
      drive(A_W'($urandom), B_W'($urandom), i[0], "R5 R8 mixed back-to-back");
    idle(LAT + 2, 0);

    // R4 streaming unsigned
    for (int i = 0; i < 100; i++)
      drive(A_W'(i * 7), B_W'(i), 0, "R4 stream");

    // R7 gaps with garbage inputs
    for (int i = 0; i < 40; i++) begin
      drive(A_W'($urandom), B_W'($urandom), $urandom, "R7 sparse requests");
      idle(1 + (i % 3), 1);
    end
    idle(LAT + 2, 1);
    check(q.size() == 0, "R4 all results delivered", q.size(), 0);

    // R6 reset with requests in flight
    drive(8'd9, 6'd9, 0, "R6 in flight");
    drive(8'd3, 6'd3, 1, "R6 in flight");
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    q.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R6 cleared next clock", out_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 flushed request stays gone", out_valid, 0);
    end

    drive(8'd12, 6'd5, 0, "R1 after reset");
    idle(LAT + 2, 0);
    check(q.size() == 0, "R4 final drain", q.size(), 0);
    finish_run();
  end
endmodule